// File: doc/BRIEF.md
# Power-down wake-up sequencer

This block controls how a microcontroller enters and leaves full power-down. Software asks for power-down by writing a request bit. The write is accepted only when the write-protection unlock is open in the same cycle. After an accepted request the system clocks keep running for a few instruction slots, so the instructions that follow the request still complete. Then every clock is gated off. While the device sleeps, only a small qualifier runs on the free-running reference clock. It watches one or both wake pins, and each pin is picked from a small set of physical inputs. A wake needs a falling edge followed by a low level that lasts long enough. Shorter low pulses are dropped.

Once a wake is qualified, the block steps through its recovery phases: regulator settle, then PLL lock. In reset mode, flash-ready and boot follow. Each phase ends when its ready input is seen high, or when its tick budget runs out. In fast mode the CPU resumes with its state intact and is never reset. In reset mode the CPU is held in reset through the whole recovery, and a sticky flag records that the wake came through a reset. Software clears that flag, or a power-on reset does. A hardware reset pulse ends power-down, or any wake in progress, at once.

Top module: `pdwake_seq`

## Requirements
- R1: After power-on reset (`rstN` low), `phase` is 0 (running), `clkRun` is 1, `cpuReset` is 0 and `wakeFromReset` is 0.
- R2: A power-down request (`pdReq`) is accepted only if `pdUnlock` is high in the same cycle. Without the unlock it has no effect and `phase` stays 0.
- R3: After an accepted request, `phase` is 1 with `clkRun` high for exactly ENTRY_SLOTS cycles. Then `phase` becomes 2 (asleep) with `clkRun` low.
- R4: While asleep, a wake needs the selected pin to be seen high, then low for QUAL_TICKS consecutive reference-clock cycles. A low pulse one cycle shorter is discarded, and `phase` stays 2.
- R5: `wakeSrc` bit 0 selects the external-interrupt pin, bit 1 the serial-receive pin, both bits set means either pin, and 0 means no pin. `extPinSel`/`rxPinSel` pick the index into `extIntIn`/`rxIn`. Pulses on unselected pins or unselected physical inputs do not wake.
- R6: A qualified wake enters `phase` 3 (regulator) and then 4 (PLL). Each phase lasts VREG_TICKS / PLL_TICKS cycles, or one cycle when its ready input (`regReady`, `pllLock`) is already high. `clkRun` is 0 in both phases.
- R7: In fast mode (`wakeMode`=0), the PLL phase is followed directly by `phase` 0. `cpuReset` is never asserted, and `wakeFromReset` keeps its value.
- R8: In reset mode (`wakeMode`=1), the PLL phase is followed by `phase` 5 (flash) and 6 (boot). These use FLASH_TICKS / BOOT_TICKS or `flashReady` / `bootDone`, with `clkRun` 1. `cpuReset` is 1 in phases 3 to 6 and is 0 after the return to phase 0.
- R9: `wakeFromReset` becomes 1 when a reset-mode wake completes. It stays 1 through hardware resets and is cleared by a `flagClr` pulse or by `rstN`.
- R10: Wake source, wake mode and pin selects are captured when the request is accepted. Changing them during power-down has no effect on that power-down.
- R11: `hwReset` high forces `phase` to 0 at the next edge from any phase and holds `cpuReset` high while asserted. An interrupted wake does not set `wakeFromReset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running reference clock |
| rstN | input | 1 | power-on reset, active low, asynchronous |
| hwReset | input | 1 | hardware reset request, synchronous |
| pdReq | input | 1 | software write of the power-down request bit |
| pdUnlock | input | 1 | write protection open |
| wakeSrc | input | 2 | wake pin enable: bit0 external interrupt, bit1 serial receive |
| wakeMode | input | 1 | 1 = reset-style wake, 0 = fast wake |
| extPinSel | input | 1 | physical input index for the external-interrupt pin |
| rxPinSel | input | 1 | physical input index for the serial-receive pin |
| extIntIn | input | 2 | external-interrupt physical inputs |
| rxIn | input | 2 | serial-receive physical inputs |
| regReady | input | 1 | regulator stable |
| pllLock | input | 1 | PLL locked |
| flashReady | input | 1 | flash ready to read |
| bootDone | input | 1 | boot code finished |
| flagClr | input | 1 | software clear of the wake-from-reset flag |
| phase | output | 3 | 0 run, 1 entry, 2 asleep, 3 regulator, 4 PLL, 5 flash, 6 boot |
| clkRun | output | 1 | system clock enable |
| cpuReset | output | 1 | CPU held in reset |
| wakeFromReset | output | 1 | sticky reset-wake flag |

## Verification
The qualifier is driven with a low pulse one tick short of the threshold and with one exactly at the threshold. This pins the minimum-low count to a single cycle. Long pulses go to an unselected pin, to the unselected physical input of each mux, and to a sleep with no source enabled, which separates source gating from pin muxing. Wakes are run with all ready inputs low, where the phase lengths must equal the tick budgets, and with all ready inputs high, where each phase lasts one cycle. Together these tell the timeout path from the early-advance path, and fast recovery from reset recovery. Configuration inputs are changed during sleep, and hardware reset is applied both while asleep and in the middle of a reset-mode wake, to show that the captured settings and the sticky flag behave independently.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;

  typedef enum logic [2:0] {
    PH_RUN   = 3'd0,
    PH_ENTRY = 3'd1,
    PH_SLEEP = 3'd2,
    PH_VREG  = 3'd3,
    PH_PLL   = 3'd4,
    PH_FLASH = 3'd5,
    PH_BOOT  = 3'd6
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCfg;
    logic cntClr;
    logic qualEn;
    logic setFlag;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic stepDone;
    logic wakeHit;
    logic resetPath;
  } dpStatus_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pdwake_qual.sv
module pdwake_qual #(
  parameter int QUAL_TICKS = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic pinIn,
  output logic hit
);
  localparam int QW = $clog2(QUAL_TICKS + 1);

  logic          armed;
  logic [QW-1:0] lowCnt;

  // armed only becomes set while enabled, so no enable term is needed here
  assign hit = armed && !pinIn && (lowCnt == QW'(QUAL_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      lowCnt <= '0;
    end else if (!en) begin
      armed  <= 1'b0;
      lowCnt <= '0;
    end else if (pinIn) begin
      armed  <= 1'b1;
      lowCnt <= '0;
    end else if (armed) begin
      if (hit) begin
        armed  <= 1'b0;
        lowCnt <= '0;
      end else begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pdwake_datapath.sv
module pdwake_datapath
  import pdwake_pkg::*;
#(
  parameter int PIN_ALTS    = 2,
  parameter int ENTRY_SLOTS = 2,
  parameter int QUAL_TICKS  = 13,
  parameter int VREG_TICKS  = 40,
  parameter int PLL_TICKS   = 50,
  parameter int FLASH_TICKS = 40,
  parameter int BOOT_TICKS  = 60
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  phase_e                      curPhase,
  input  logic [1:0]                  wakeSrc,
  input  logic                        wakeMode,
  input  logic [$clog2(PIN_ALTS)-1:0] extPinSel,
  input  logic [$clog2(PIN_ALTS)-1:0] rxPinSel,
  input  logic [PIN_ALTS-1:0]         extIntIn,
  input  logic [PIN_ALTS-1:0]         rxIn,
  input  logic                        regReady,
  input  logic                        pllLock,
  input  logic                        flashReady,
  input  logic                        bootDone,
  input  logic                        flagClr,
  output dpStatus_t                   status,
  output logic                        wakeFromReset
);
  localparam int SEL_W  = $clog2(PIN_ALTS);
  localparam int MAX_T  = maxOf(maxOf(ENTRY_SLOTS, VREG_TICKS),
                                maxOf(PLL_TICKS, maxOf(FLASH_TICKS, BOOT_TICKS)));
  localparam int CNT_W  = $clog2(MAX_T + 1);
  localparam int N_SRC  = 2;

  logic [1:0]       cfgSrc;
  logic             cfgMode;
  logic [SEL_W-1:0] cfgExtSel;
  logic [SEL_W-1:0] cfgRxSel;
  logic [CNT_W-1:0] cnt;
  logic [N_SRC-1:0] srcPin;
  logic [N_SRC-1:0] srcHit;

  // configuration captured at the accepted request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSrc    <= '0;
      cfgMode   <= 1'b0;
      cfgExtSel <= '0;
      cfgRxSel  <= '0;
    end else if (strobe.latchCfg) begin
      cfgSrc    <= wakeSrc;
      cfgMode   <= wakeMode;
      cfgExtSel <= extPinSel;
      cfgRxSel  <= rxPinSel;
    end
  end

  assign srcPin[0] = extIntIn[cfgExtSel];
  assign srcPin[1] = rxIn[cfgRxSel];

  for (genvar i = 0; i < N_SRC; i++) begin : g_qual
    pdwake_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
      .clk   (clk),
      .rstN  (rstN),
      .en    (strobe.qualEn && cfgSrc[i]),
      .pinIn (srcPin[i]),
      .hit   (srcHit[i])
    );
  end

  // phase tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  always_comb begin
    unique case (curPhase)
      PH_ENTRY: status.stepDone = (cnt == CNT_W'(ENTRY_SLOTS - 1));
      PH_VREG:  status.stepDone = regReady   || (cnt == CNT_W'(VREG_TICKS - 1));
      PH_PLL:   status.stepDone = pllLock    || (cnt == CNT_W'(PLL_TICKS - 1));
      PH_FLASH: status.stepDone = flashReady || (cnt == CNT_W'(FLASH_TICKS - 1));
      PH_BOOT:  status.stepDone = bootDone   || (cnt == CNT_W'(BOOT_TICKS - 1));
      default:  status.stepDone = 1'b0;
    endcase
  end

  assign status.wakeHit   = |(srcHit & cfgSrc);
  assign status.resetPath = cfgMode;

  // sticky flag: only power-on reset or software clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               wakeFromReset <= 1'b0;
    else if (strobe.setFlag) wakeFromReset <= 1'b1;
    else if (flagClr)        wakeFromReset <= 1'b0;
  end
endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
  import pdwake_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hwReset,
  input  logic        pdReq,
  input  logic        pdUnlock,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output phase_e      curPhase,
  output logic        clkRun,
  output logic        cpuReset
);
  phase_e state, nextState;
  logic   reqOk;

  assign reqOk = pdReq && pdUnlock;

  always_comb begin
    nextState = state;
    unique case (state)
      PH_RUN:   if (reqOk)           nextState = PH_ENTRY;
      PH_ENTRY: if (status.stepDone) nextState = PH_SLEEP;
      PH_SLEEP: if (status.wakeHit)  nextState = PH_VREG;
      PH_VREG:  if (status.stepDone) nextState = PH_PLL;
      PH_PLL:   if (status.stepDone) nextState = status.resetPath ? PH_FLASH : PH_RUN;
      PH_FLASH: if (status.stepDone) nextState = PH_BOOT;
      PH_BOOT:  if (status.stepDone) nextState = PH_RUN;
      default:                       nextState = PH_RUN;
    endcase
    if (hwReset) nextState = PH_RUN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_RUN;
    else       state <= nextState;
  end

  assign strobe.latchCfg = (state == PH_RUN) && reqOk && !hwReset;
  assign strobe.cntClr   = (nextState != state);
  assign strobe.qualEn   = (state == PH_SLEEP);
  assign strobe.setFlag  = (state == PH_BOOT) && status.stepDone && !hwReset;

  assign curPhase = state;
  assign clkRun   = (state == PH_RUN) || (state == PH_ENTRY) ||
                    (state == PH_FLASH) || (state == PH_BOOT);
  assign cpuReset = hwReset ||
                    (status.resetPath && ((state == PH_VREG) || (state == PH_PLL) ||
                                          (state == PH_FLASH) || (state == PH_BOOT)));
endmodule

// File: rtl/pdwake_seq.sv
module pdwake_seq
  import pdwake_pkg::*;
#(
  parameter int PIN_ALTS    = 2,
  parameter int ENTRY_SLOTS = 2,
  parameter int QUAL_TICKS  = 13,
  parameter int VREG_TICKS  = 40,
  parameter int PLL_TICKS   = 50,
  parameter int FLASH_TICKS = 40,
  parameter int BOOT_TICKS  = 60
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        hwReset,
  input  logic                        pdReq,
  input  logic                        pdUnlock,
  input  logic [1:0]                  wakeSrc,
  input  logic                        wakeMode,
  input  logic [$clog2(PIN_ALTS)-1:0] extPinSel,
  input  logic [$clog2(PIN_ALTS)-1:0] rxPinSel,
  input  logic [PIN_ALTS-1:0]         extIntIn,
  input  logic [PIN_ALTS-1:0]         rxIn,
  input  logic                        regReady,
  input  logic                        pllLock,
  input  logic                        flashReady,
  input  logic                        bootDone,
  input  logic                        flagClr,
  output logic [2:0]                  phase,
  output logic                        clkRun,
  output logic                        cpuReset,
  output logic                        wakeFromReset
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  phase_e      curPhase;

  pdwake_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hwReset  (hwReset),
    .pdReq    (pdReq),
    .pdUnlock (pdUnlock),
    .status   (status),
    .strobe   (strobe),
    .curPhase (curPhase),
    .clkRun   (clkRun),
    .cpuReset (cpuReset)
  );

  pdwake_datapath #(
    .PIN_ALTS    (PIN_ALTS),
    .ENTRY_SLOTS (ENTRY_SLOTS),
    .QUAL_TICKS  (QUAL_TICKS),
    .VREG_TICKS  (VREG_TICKS),
    .PLL_TICKS   (PLL_TICKS),
    .FLASH_TICKS (FLASH_TICKS),
    .BOOT_TICKS  (BOOT_TICKS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .curPhase      (curPhase),
    .wakeSrc       (wakeSrc),
    .wakeMode      (wakeMode),
    .extPinSel     (extPinSel),
    .rxPinSel      (rxPinSel),
    .extIntIn      (extIntIn),
    .rxIn          (rxIn),
    .regReady      (regReady),
    .pllLock       (pllLock),
    .flashReady    (flashReady),
    .bootDone      (bootDone),
    .flagClr       (flagClr),
    .status        (status),
    .wakeFromReset (wakeFromReset)
  );

  assign phase = curPhase;
endmodule

// File: rtl/pdwake_checker.sv
module pdwake_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hwReset,
  input logic       pdReq,
  input logic       pdUnlock,
  input logic       flagClr,
  input logic [2:0] phase,
  input logic       clkRun,
  input logic       cpuReset,
  input logic       wakeFromReset
);
  assert_locked_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd0 && !(pdReq && pdUnlock)) |=> phase != 3'd1);

  assert_sleep_clock_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd2) |-> !clkRun);

  assert_wake_from_sleep_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd3 && $past(phase) != 3'd3) |-> $past(phase) == 3'd2);

  assert_reset_only_recovery_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReset && !hwReset) |-> (phase >= 3'd3 && phase <= 3'd6));

  assert_late_phases_clocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 3'd5 || phase == 3'd6) |-> (clkRun && cpuReset));

  assert_flag_set_from_boot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFromReset) |-> $past(phase) == 3'd6);

  assert_flag_cleared_by_sw_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wakeFromReset) |-> $past(flagClr));

  assert_hw_reset_exit_R11: assert property (@(posedge clk) disable iff (!rstN)
    hwReset |=> phase == 3'd0);
endmodule

bind pdwake_seq pdwake_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .hwReset       (hwReset),
  .pdReq         (pdReq),
  .pdUnlock      (pdUnlock),
  .flagClr       (flagClr),
  .phase         (phase),
  .clkRun        (clkRun),
  .cpuReset      (cpuReset),
  .wakeFromReset (wakeFromReset)
);

// File: tb/pdwake_seq_bench.sv
module pdwake_seq_bench;
  localparam int ENTRY = 2;
  localparam int QUAL  = 13;
  localparam int VREG  = 40;
  localparam int PLL   = 50;
  localparam int FLASH = 40;
  localparam int BOOT  = 60;

  logic       clk = 1'b0;
  logic       rstN, hwReset, pdReq, pdUnlock, wakeMode, extPinSel, rxPinSel;
  logic [1:0] wakeSrc, extIntIn, rxIn;
  logic       regReady, pllLock, flashReady, bootDone, flagClr;
  logic [2:0] phase;
  logic       clkRun, cpuReset, wakeFromReset;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pdwake_seq #(
    .PIN_ALTS(2), .ENTRY_SLOTS(ENTRY), .QUAL_TICKS(QUAL), .VREG_TICKS(VREG),
    .PLL_TICKS(PLL), .FLASH_TICKS(FLASH), .BOOT_TICKS(BOOT)
  ) u_pdwake_seq (
    .clk(clk), .rstN(rstN), .hwReset(hwReset), .pdReq(pdReq), .pdUnlock(pdUnlock),
    .wakeSrc(wakeSrc), .wakeMode(wakeMode), .extPinSel(extPinSel), .rxPinSel(rxPinSel),
    .extIntIn(extIntIn), .rxIn(rxIn), .regReady(regReady), .pllLock(pllLock),
    .flashReady(flashReady), .bootDone(bootDone), .flagClr(flagClr),
    .phase(phase), .clkRun(clkRun), .cpuReset(cpuReset), .wakeFromReset(wakeFromReset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic enterSleep(input bit mode, input logic [1:0] src, input bit eSel, input bit rSel);
    int n;
    wakeMode = mode; wakeSrc = src; extPinSel = eSel; rxPinSel = rSel;
    pdReq = 1'b1; pdUnlock = 1'b1;
    @(negedge clk);
    pdReq = 1'b0; pdUnlock = 1'b0;
    n = 0;
    while (phase == 3'd1 && clkRun && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(n == ENTRY, "R3 entry slots", n, ENTRY);
    check(phase == 3'd2 && !clkRun, "R3 asleep with clocks off", int'(phase), 2);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(input bit onRx, input int idx, input int len);
    if (onRx) rxIn[idx] = 1'b0; else extIntIn[idx] = 1'b0;
    repeat (len) @(negedge clk);
    if (onRx) rxIn[idx] = 1'b1; else extIntIn[idx] = 1'b1;
  endtask

  task automatic runWake(output int v, output int p, output int f, output int b,
                         output bit rstAll, output bit rstAny, output bit clkOk);
    int g;
    v = 0; p = 0; f = 0; b = 0; rstAll = 1; rstAny = 0; clkOk = 1; g = 0;
    while (phase != 3'd0 && g < 1000) begin
      case (phase)
        3'd3: v++;
        3'd4: p++;
        3'd5: f++;
        3'd6: b++;
        default: ;
      endcase
      if (cpuReset) rstAny = 1; else rstAll = 0;
      if ((phase == 3'd3 || phase == 3'd4) && clkRun) clkOk = 0;
      if ((phase == 3'd5 || phase == 3'd6) && !clkRun) clkOk = 0;
      @(negedge clk);
      g++;
    end
  endtask

  task automatic testReset;
    check(phase == 3'd0, "R1 phase", int'(phase), 0);
    check(clkRun && !cpuReset && !wakeFromReset, "R1 outputs",
          {clkRun, cpuReset, wakeFromReset}, 3'b100);
  endtask

  task automatic testLocked;
    pdReq = 1'b1; pdUnlock = 1'b0;
    @(negedge clk);
    pdReq = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == 3'd0 && clkRun, "R2 locked request ignored", int'(phase), 0);
  endtask

  task automatic testFastWake;
    int v, p, f, b; bit ra, rn, ck;
    enterSleep(1'b0, 2'b01, 1'b0, 1'b0);
    pulse(1'b0, 0, QUAL - 1);
    repeat (20) @(negedge clk);
    check(phase == 3'd2, "R4 short pulse discarded", int'(phase), 2);
    pulse(1'b1, 0, QUAL + 2);
    repeat (3) @(negedge clk);
    check(phase == 3'd2, "R5 unselected rx pin", int'(phase), 2);
    pulse(1'b0, 1, QUAL + 2);
    repeat (3) @(negedge clk);
    check(phase == 3'd2, "R5 unselected physical input", int'(phase), 2);
    pulse(1'b0, 0, QUAL);
    check(phase == 3'd3, "R4 threshold pulse wakes", int'(phase), 3);
    runWake(v, p, f, b, ra, rn, ck);
    check(v == VREG, "R6 regulator timeout", v, VREG);
    check(p == PLL, "R6 pll timeout", p, PLL);
    check(ck, "R6 clock gating in recovery", ck, 1);
    check(f == 0 && b == 0, "R7 fast path skips flash and boot", f + b, 0);
    check(!rn, "R7 no cpu reset in fast wake", rn, 0);
    check(phase == 3'd0 && !wakeFromReset, "R7 back to run, flag clear",
          {phase, wakeFromReset}, 0);
  endtask

  task automatic testResetWake;
    int v, p, f, b; bit ra, rn, ck;
    enterSleep(1'b1, 2'b10, 1'b0, 1'b1);
    wakeMode = 1'b0; wakeSrc = 2'b01;
    pulse(1'b0, 0, QUAL + 2);
    repeat (3) @(negedge clk);
    check(phase == 3'd2, "R10 source change during sleep ignored", int'(phase), 2);
    pulse(1'b1, 0, QUAL + 2);
    repeat (3) @(negedge clk);
    check(phase == 3'd2, "R5 unselected rx physical input", int'(phase), 2);
    pulse(1'b1, 1, QUAL);
    check(phase == 3'd3, "R5 selected rx input wakes", int'(phase), 3);
    runWake(v, p, f, b, ra, rn, ck);
    check(f == FLASH && b == BOOT, "R8 flash and boot timeouts", f * 1000 + b, FLASH * 1000 + BOOT);
    check(f == FLASH, "R10 mode kept as reset during sleep", f, FLASH);
    check(ra && ck, "R8 cpu reset and clocks through recovery", {ra, ck}, 3);
    check(!cpuReset && clkRun, "R8 cpu released", cpuReset, 0);
    check(wakeFromReset, "R9 flag set by reset wake", wakeFromReset, 1);
  endtask

  task automatic testReadyEarly;
    int v, p, f, b; bit ra, rn, ck;
    enterSleep(1'b1, 2'b11, 1'b1, 1'b0);
    regReady = 1; pllLock = 1; flashReady = 1; bootDone = 1;
    pulse(1'b0, 1, QUAL);
    check(phase == 3'd3, "R5 either-pin select, ext input 1", int'(phase), 3);
    runWake(v, p, f, b, ra, rn, ck);
    check(v == 1 && p == 1, "R6 ready inputs end phases early", v + p, 2);
    check(f == 1 && b == 1, "R8 ready inputs end late phases early", f + b, 2);
    regReady = 0; pllLock = 0; flashReady = 0; bootDone = 0;
  endtask

  task automatic testEitherRx;
    int v, p, f, b; bit ra, rn, ck;
    enterSleep(1'b0, 2'b11, 1'b0, 1'b0);
    pulse(1'b1, 0, QUAL);
    check(phase == 3'd3, "R5 either-pin select, rx", int'(phase), 3);
    runWake(v, p, f, b, ra, rn, ck);
    check(f == 0 && !rn, "R7 fast wake without reset", f + rn, 0);
    check(wakeFromReset, "R7 flag unchanged by fast wake", wakeFromReset, 1);
  endtask

  task automatic testNoSourceHwReset;
    enterSleep(1'b0, 2'b00, 1'b0, 1'b0);
    pulse(1'b0, 0, QUAL + 2);
    pulse(1'b1, 0, QUAL + 2);
    repeat (3) @(negedge clk);
    check(phase == 3'd2, "R5 no source selected stays asleep", int'(phase), 2);
    hwReset = 1'b1;
    @(negedge clk);
    check(phase == 3'd0 && cpuReset, "R11 hardware reset exits sleep", {phase, cpuReset}, 1);
    hwReset = 1'b0;
    @(negedge clk);
    check(!cpuReset && clkRun, "R11 reset released", cpuReset, 0);
    check(wakeFromReset, "R9 flag survives hardware reset", wakeFromReset, 1);
  endtask

  task automatic testFlagClear;
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check(!wakeFromReset, "R9 software clear", wakeFromReset, 0);
  endtask

  task automatic testHwResetMidWake;
    enterSleep(1'b1, 2'b01, 1'b0, 1'b0);
    pulse(1'b0, 0, QUAL);
    repeat (5) @(negedge clk);
    hwReset = 1'b1;
    @(negedge clk);
    hwReset = 1'b0;
    check(phase == 3'd0, "R11 hardware reset aborts wake", int'(phase), 0);
    repeat (3) @(negedge clk);
    check(!wakeFromReset && phase == 3'd0, "R11 aborted wake leaves flag clear",
          wakeFromReset, 0);
  endtask

  initial begin
    rstN = 0; hwReset = 0; pdReq = 0; pdUnlock = 0; wakeSrc = 0; wakeMode = 0;
    extPinSel = 0; rxPinSel = 0; extIntIn = 2'b11; rxIn = 2'b11;
    regReady = 0; pllLock = 0; flashReady = 0; bootDone = 0; flagClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset;
    testLocked;
    testFastWake;
    testResetWake;
    testReadyEarly;
    testEitherRx;
    testNoSourceHwReset;
    testFlagClear;
    testHwResetMidWake;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule